// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Bank

This block holds a small set of one-bit lock flags that two processors, one on a left port and one on a right port, use to agree on who may touch a shared resource. The flags sit in their own address space next to the shared data memory. Each port reaches them through its own semaphore select, which is separate from the memory select. A port asks for a flag by writing to it, then reads the flag to learn whether the request succeeded. Hardware settles requests that arrive at the same time, so one port at most ever holds a given flag.

Ownership and requests are kept as separate per-port state for each flag. A request that cannot be served at once stays pending. When the owner lets go of the flag, the pending request is served on that same clock edge, without any further action by the waiting port. Each port also reports standby while neither of its two selects is active.

Top module: `sem_flag_unit`

## Requirements
- R1: The bank has eight independent flags, indexed 0 to 7 by a 3-bit index. After reset no port owns any flag and none has a request pending.
- R2: With its semaphore select low, a port reads 0 on its read bit when it owns the indexed flag and 1 when it does not. With the select high, the read bit is 1.
- R3: The two ports never own the same flag at the same time.
- R4: A write with data bit 0 is a request. A request to a free flag is granted at the clock edge that accepts the write, so the port reads 0 from the next cycle on.
- R5: When both ports request the same free flag in the same cycle, the left port is granted and the right request stays pending.
- R6: A write with data bit 1 from the owner is a release. If the other port has a request pending for that flag, ownership passes to it on the same edge. Otherwise the flag becomes free.
- R7: A release from a port that does not own the flag leaves the other port's ownership unchanged and clears any request the releasing port has pending for that flag.
- R8: A port's standby output is 1 exactly when its memory select and its semaphore select are both high.
- R9: A write while the port's semaphore select is high has no effect on any flag. An owner that requests its flag again keeps it and gains no pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| l_mem_en_ni | input | 1 | Left memory select, active low (used only for standby) |
| l_sem_en_ni | input | 1 | Left semaphore select, active low |
| l_wr_i | input | 1 | Left write strobe, active high |
| l_idx_i | input | 3 | Left flag index |
| l_wbit_i | input | 1 | Left write data bit: 0 request, 1 release |
| l_rbit_o | output | 1 | Left read bit: 0 when the left port owns the indexed flag |
| l_standby_o | output | 1 | Left port in standby |
| r_mem_en_ni | input | 1 | Right memory select, active low (used only for standby) |
| r_sem_en_ni | input | 1 | Right semaphore select, active low |
| r_wr_i | input | 1 | Right write strobe, active high |
| r_idx_i | input | 3 | Right flag index |
| r_wbit_i | input | 1 | Right write data bit: 0 request, 1 release |
| r_rbit_o | output | 1 | Right read bit: 0 when the right port owns the indexed flag |
| r_standby_o | output | 1 | Right port in standby |

## Verification
A wrong owner or pending bit shows at the ports only when a port reads the affected flag. A stale pending bit stays hidden until the owner releases and the flag then goes to the wrong port. The bench therefore reads both ports every cycle and sweeps the indices. This way a bad grant shows in the cycle after the edge that caused it, and a bad pending bit shows in the cycle after the next release of that flag.

// File: rtl/sem_flag_pkg.sv
package sem_flag_pkg;
  typedef enum logic [1:0] {
    HOLD_NONE  = 2'd0,
    HOLD_LEFT  = 2'd1,
    HOLD_RIGHT = 2'd2
  } holder_e;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int N_FLAGS = 8,
  localparam int IDX_W = $clog2(N_FLAGS)
) (
  input  logic               mem_en_ni,
  input  logic               sem_en_ni,
  input  logic               wr_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               wbit_i,
  output logic [N_FLAGS-1:0] req_o,
  output logic [N_FLAGS-1:0] rel_o,
  output logic               standby_o
);
  logic acc_wr;

  assign acc_wr    = ~sem_en_ni & wr_i;
  assign standby_o = mem_en_ni & sem_en_ni;

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_sel
    logic hit;
    assign hit      = acc_wr && (idx_i == IDX_W'(g));
    assign req_o[g] = hit & ~wbit_i;
    assign rel_o[g] = hit &  wbit_i;
  end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_flag_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic l_req_i,
  input  logic l_rel_i,
  input  logic r_req_i,
  input  logic r_rel_i,
  output logic own_l_o,
  output logic own_r_o,
  output logic pend_l_o,
  output logic pend_r_o
);
  holder_e holder_q, holder_d, held;
  logic    pend_l_q, pend_l_d, pend_r_q, pend_r_d;
  logic    want_l, want_r, upd_en;

  // State moves only on a write to this flag.
  assign upd_en = l_req_i | l_rel_i | r_req_i | r_rel_i;

  always_comb begin
    want_l = (pend_l_q | l_req_i) & ~l_rel_i;
    want_r = (pend_r_q | r_req_i) & ~r_rel_i;

    held = holder_q;
    if (holder_q == HOLD_LEFT && l_rel_i)  held = HOLD_NONE;
    if (holder_q == HOLD_RIGHT && r_rel_i) held = HOLD_NONE;

    holder_d = held;
    if (held == HOLD_NONE) begin
      if (want_l)      holder_d = HOLD_LEFT;
      else if (want_r) holder_d = HOLD_RIGHT;
    end

    pend_l_d = want_l && (holder_d != HOLD_LEFT);
    pend_r_d = want_r && (holder_d != HOLD_RIGHT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      holder_q <= HOLD_NONE;
      pend_l_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else if (upd_en) begin
      holder_q <= holder_d;
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
    end
  end

  assign own_l_o  = (holder_q == HOLD_LEFT);
  assign own_r_o  = (holder_q == HOLD_RIGHT);
  assign pend_l_o = pend_l_q;
  assign pend_r_o = pend_r_q;
endmodule

// File: rtl/sem_read_mux.sv
module sem_read_mux #(
  parameter int N_FLAGS = 8,
  localparam int IDX_W = $clog2(N_FLAGS)
) (
  input  logic               sem_en_ni,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [N_FLAGS-1:0] own_i,
  output logic               rbit_o
);
  always_comb begin
    rbit_o = 1'b1;
    if (!sem_en_ni) rbit_o = ~own_i[idx_i];
  end
endmodule

// File: rtl/sem_flag_unit.sv
module sem_flag_unit #(
  parameter int N_FLAGS = 8,
  localparam int IDX_W = $clog2(N_FLAGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             l_mem_en_ni,
  input  logic             l_sem_en_ni,
  input  logic             l_wr_i,
  input  logic [IDX_W-1:0] l_idx_i,
  input  logic             l_wbit_i,
  output logic             l_rbit_o,
  output logic             l_standby_o,
  input  logic             r_mem_en_ni,
  input  logic             r_sem_en_ni,
  input  logic             r_wr_i,
  input  logic [IDX_W-1:0] r_idx_i,
  input  logic             r_wbit_i,
  output logic             r_rbit_o,
  output logic             r_standby_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_sync_n;
  logic [N_FLAGS-1:0] l_req, l_rel, r_req, r_rel;
  logic [N_FLAGS-1:0] own_l, own_r, pend_l, pend_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  sem_port_dec #(.N_FLAGS(N_FLAGS)) u_dec_l (
    .mem_en_ni(l_mem_en_ni), .sem_en_ni(l_sem_en_ni), .wr_i(l_wr_i),
    .idx_i(l_idx_i), .wbit_i(l_wbit_i),
    .req_o(l_req), .rel_o(l_rel), .standby_o(l_standby_o)
  );

  sem_port_dec #(.N_FLAGS(N_FLAGS)) u_dec_r (
    .mem_en_ni(r_mem_en_ni), .sem_en_ni(r_sem_en_ni), .wr_i(r_wr_i),
    .idx_i(r_idx_i), .wbit_i(r_wbit_i),
    .req_o(r_req), .rel_o(r_rel), .standby_o(r_standby_o)
  );

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    sem_flag_cell u_cell (
      .clk_i(clk_i), .rst_ni(rst_sync_n),
      .l_req_i(l_req[g]), .l_rel_i(l_rel[g]),
      .r_req_i(r_req[g]), .r_rel_i(r_rel[g]),
      .own_l_o(own_l[g]), .own_r_o(own_r[g]),
      .pend_l_o(pend_l[g]), .pend_r_o(pend_r[g])
    );
  end

  sem_read_mux #(.N_FLAGS(N_FLAGS)) u_rd_l (
    .sem_en_ni(l_sem_en_ni), .idx_i(l_idx_i), .own_i(own_l), .rbit_o(l_rbit_o)
  );

  sem_read_mux #(.N_FLAGS(N_FLAGS)) u_rd_r (
    .sem_en_ni(r_sem_en_ni), .idx_i(r_idx_i), .own_i(own_r), .rbit_o(r_rbit_o)
  );
endmodule

// File: rtl/sem_flag_unit_chk.sv
module sem_flag_unit_chk #(
  parameter int N_FLAGS = 8,
  localparam int IDX_W = $clog2(N_FLAGS)
) (
  input logic               clk_i,
  input logic               rst_n,
  input logic               l_sem_en_ni,
  input logic [IDX_W-1:0]   l_idx_i,
  input logic               l_rbit_o,
  input logic               r_sem_en_ni,
  input logic [IDX_W-1:0]   r_idx_i,
  input logic               r_rbit_o,
  input logic [N_FLAGS-1:0] l_req,
  input logic [N_FLAGS-1:0] l_rel,
  input logic [N_FLAGS-1:0] r_req,
  input logic [N_FLAGS-1:0] r_rel,
  input logic [N_FLAGS-1:0] own_l,
  input logic [N_FLAGS-1:0] own_r,
  input logic [N_FLAGS-1:0] pend_l,
  input logic [N_FLAGS-1:0] pend_r
);
  // R3: both read ports never report ownership of one flag together
  a_r3_port_exclusive: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!l_sem_en_ni && !r_sem_en_ni && l_idx_i == r_idx_i) |-> (l_rbit_o | r_rbit_o));

  // R2: owner reads 0 on the left port
  a_r2_left_owner_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!l_sem_en_ni && own_l[l_idx_i]) |-> !l_rbit_o);

  // R2: deselected right port reads 1
  a_r2_right_idle_reads_one: assert property (@(posedge clk_i) disable iff (!rst_n)
    r_sem_en_ni |-> r_rbit_o);

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_chk
    // R5: simultaneous request on a free flag goes left
    a_r5_tie_left: assert property (@(posedge clk_i) disable iff (!rst_n)
      (l_req[g] && r_req[g] && !own_l[g] && !own_r[g]) |=> (own_l[g] && pend_r[g]));

    // R6: release by owner hands over to the pending side
    a_r6_handover: assert property (@(posedge clk_i) disable iff (!rst_n)
      (own_l[g] && l_rel[g] && pend_r[g] && !r_rel[g]) |=> own_r[g]);

    // R7: foreign release keeps the holder and drops own pending request
    a_r7_foreign_release: assert property (@(posedge clk_i) disable iff (!rst_n)
      (own_l[g] && r_rel[g] && !l_rel[g]) |=> (own_l[g] && !pend_r[g]));

    // R9: an owner never carries a pending request on its own flag
    a_r9_no_self_pending: assert property (@(posedge clk_i) disable iff (!rst_n)
      !(own_l[g] && pend_l[g]) && !(own_r[g] && pend_r[g]));

    // R3: internal holder bits never both set
    a_r3_single_holder: assert property (@(posedge clk_i) disable iff (!rst_n)
      !(own_l[g] && own_r[g]));
  end
endmodule

bind sem_flag_unit sem_flag_unit_chk #(.N_FLAGS(N_FLAGS)) chk_i (
  .clk_i(clk_i), .rst_n(rst_sync_n),
  .l_sem_en_ni(l_sem_en_ni), .l_idx_i(l_idx_i), .l_rbit_o(l_rbit_o),
  .r_sem_en_ni(r_sem_en_ni), .r_idx_i(r_idx_i), .r_rbit_o(r_rbit_o),
  .l_req(l_req), .l_rel(l_rel), .r_req(r_req), .r_rel(r_rel),
  .own_l(own_l), .own_r(own_r), .pend_l(pend_l), .pend_r(pend_r)
);

// File: tb/sem_flag_unit_tb_top.sv
module sem_flag_unit_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       l_mem_en_ni, l_sem_en_ni, l_wr_i, l_wbit_i;
  logic [2:0] l_idx_i;
  logic       r_mem_en_ni, r_sem_en_ni, r_wr_i, r_wbit_i;
  logic [2:0] r_idx_i;
  logic       l_rbit_o, l_standby_o, r_rbit_o, r_standby_o;

  int n_vec  = 0;
  int n_miss = 0;
  int cycles = 0;
  bit done   = 0;

  // behavioural reference: 0 free, 1 left, 2 right
  int holder [8];
  bit wait_l [8];
  bit wait_r [8];

  always #5 clk_i = ~clk_i;

  sem_flag_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .l_mem_en_ni(l_mem_en_ni), .l_sem_en_ni(l_sem_en_ni), .l_wr_i(l_wr_i),
    .l_idx_i(l_idx_i), .l_wbit_i(l_wbit_i), .l_rbit_o(l_rbit_o), .l_standby_o(l_standby_o),
    .r_mem_en_ni(r_mem_en_ni), .r_sem_en_ni(r_sem_en_ni), .r_wr_i(r_wr_i),
    .r_idx_i(r_idx_i), .r_wbit_i(r_wbit_i), .r_rbit_o(r_rbit_o), .r_standby_o(r_standby_o)
  );

  task automatic check(string tag, string what, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin
      holder[i] = 0; wait_l[i] = 0; wait_r[i] = 0;
    end
  endtask

  function automatic logic exp_read(logic sel_n, logic [2:0] idx, int me);
    if (sel_n) return 1'b1;
    return (holder[idx] == me) ? 1'b0 : 1'b1;
  endfunction

  task automatic model_clock();
    for (int i = 0; i < 8; i++) begin
      bit lw, lr, rw, rr, lwant, rwant;
      lw = !l_sem_en_ni && l_wr_i && l_idx_i == 3'(i) && !l_wbit_i;
      lr = !l_sem_en_ni && l_wr_i && l_idx_i == 3'(i) &&  l_wbit_i;
      rw = !r_sem_en_ni && r_wr_i && r_idx_i == 3'(i) && !r_wbit_i;
      rr = !r_sem_en_ni && r_wr_i && r_idx_i == 3'(i) &&  r_wbit_i;
      lwant = lr ? 0 : (wait_l[i] || lw);
      rwant = rr ? 0 : (wait_r[i] || rw);
      if ((holder[i] == 1 && lr) || (holder[i] == 2 && rr)) holder[i] = 0;
      if (holder[i] == 0) begin
        if (lwant) holder[i] = 1;
        else if (rwant) holder[i] = 2;
      end
      wait_l[i] = lwant && holder[i] != 1;
      wait_r[i] = rwant && holder[i] != 2;
    end
  endtask

  // apply one cycle: drive at negedge, compare, then advance the model
  task automatic cyc(string tag,
                     logic lm, logic ls, logic lw, logic [2:0] li, logic lb,
                     logic rm, logic rs, logic rw, logic [2:0] ri, logic rb);
    @(negedge clk_i);
    l_mem_en_ni = lm; l_sem_en_ni = ls; l_wr_i = lw; l_idx_i = li; l_wbit_i = lb;
    r_mem_en_ni = rm; r_sem_en_ni = rs; r_wr_i = rw; r_idx_i = ri; r_wbit_i = rb;
    #1;
    check(tag, "l_rbit", l_rbit_o, exp_read(ls, li, 1));
    check(tag, "r_rbit", r_rbit_o, exp_read(rs, ri, 2));
    check("R8", "l_standby", l_standby_o, lm & ls);
    check("R8", "r_standby", r_standby_o, rm & rs);
    if (!ls && !rs && li == ri)
      check("R3", "both_own", l_rbit_o | r_rbit_o, 1'b1);
    @(posedge clk_i);
    model_clock();
  endtask

  task automatic rd(string tag, logic [2:0] li, logic [2:0] ri);
    cyc(tag, 1, 0, 0, li, 0, 1, 0, 0, ri, 0);
  endtask

  task automatic idle();
    cyc("R8", 1, 1, 0, 0, 0, 1, 1, 0, 0, 0);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 100000) begin
        n_miss++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
      end
    end
  end

  initial begin : stim
    rst_ni = 1'b0;
    l_mem_en_ni = 1; l_sem_en_ni = 1; l_wr_i = 0; l_idx_i = 0; l_wbit_i = 1;
    r_mem_en_ni = 1; r_sem_en_ni = 1; r_wr_i = 0; r_idx_i = 0; r_wbit_i = 1;
    model_reset();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);

    // R1: every flag free after reset
    for (int i = 0; i < 8; i++) rd("R1", 3'(i), 3'(7 - i));

    // R4: left takes flag 2, both read
    cyc("R4", 1, 0, 1, 2, 0, 1, 1, 0, 0, 0);
    rd("R4", 2, 2);
    // R2: reads on other indices and deselected reads
    rd("R2", 3, 2);
    cyc("R2", 0, 1, 0, 2, 0, 0, 1, 0, 2, 0);

    // R5: both request flag 5 together
    cyc("R5", 1, 0, 1, 5, 0, 1, 0, 1, 5, 0);
    rd("R5", 5, 5);

    // R7: right releases flag 5 it does not own (clears its pending)
    cyc("R7", 1, 0, 0, 5, 0, 1, 0, 1, 5, 1);
    rd("R7", 5, 5);
    // left release then: flag must go free, not to right
    cyc("R7", 1, 0, 1, 5, 1, 1, 1, 0, 0, 0);
    rd("R7", 5, 5);

    // R6: left owns 2; right queues, left releases, hand-over
    cyc("R6", 1, 1, 0, 0, 0, 1, 0, 1, 2, 0);
    rd("R6", 2, 2);
    cyc("R6", 1, 0, 1, 2, 1, 1, 1, 0, 0, 0);
    rd("R6", 2, 2);
    // right releases with no one waiting
    cyc("R6", 1, 1, 0, 0, 0, 1, 0, 1, 2, 1);
    rd("R6", 2, 2);

    // R9: writes with the select high are ignored
    cyc("R9", 0, 1, 1, 4, 0, 0, 1, 1, 4, 0);
    rd("R9", 4, 4);
    // R9: owner re-request keeps flag, no stale pending
    cyc("R9", 1, 0, 1, 6, 0, 1, 1, 0, 0, 0);
    cyc("R9", 1, 0, 1, 6, 0, 1, 1, 0, 0, 0);
    cyc("R9", 1, 0, 1, 6, 1, 1, 1, 0, 0, 0);
    rd("R9", 6, 6);

    // R8: all standby combinations
    cyc("R8", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    cyc("R8", 1, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    idle();

    // R1: independence of flags, all claimed alternately
    for (int i = 0; i < 8; i++)
      cyc("R1", 1, 0, (i % 2) == 0, 3'(i), 0, 1, 0, (i % 2) == 1, 3'(i), 0);
    for (int i = 0; i < 8; i++) rd("R1", 3'(i), 3'(i));

    // random traffic against the reference
    for (int n = 0; n < 2000; n++) begin
      logic [15:0] v;
      v = 16'($urandom);
      cyc("R2", v[0], v[1] & v[2], v[3], v[6:4], v[7],
                v[8], v[9] & v[10], v[11], v[14:12], v[15]);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end
endmodule